// File: doc/BRIEF.md
# Head Temperature-Sense Control Register

This block holds the ten configuration bits that steer a print-head temperature measurement path. A host shifts a word in serially, most significant bit first, on the rising edges of a dedicated serial clock. A level-sensitive latch enable then passes that word to the decoded outputs. The latch is transparent: while the enable is high, the outputs track the shift register. While it is low, they keep the last word seen. Tying the enable high makes every shifted bit visible directly.

All three serial-side inputs are asynchronous to the core clock. They pass through a synchroniser of `SYNC_STAGES` flops. A shift happens on each synchronised rising edge of the serial clock. A two-state latch controller then copies the shift register into the holding word on every core cycle for which it is in its tracking state.

The decoder splits the held word into the following outputs:
- a head A/B select;
- a 5-bit offset-DAC code;
- a 3-bit converter channel address, with its one-hot select vector;
- three category flags: internal sense channel, external general-purpose channel, and special switch setting.

The current-source enable is the held on/off bit gated by an active-low external pin.

The latch controller has two states:
- `LT_HOLD`: the holding word is frozen.
- `LT_TRACK`: the holding word copies the shift register every cycle.

The controller has two transitions:
- `LT_HOLD` moves to `LT_TRACK` when the synchronised latch enable is high.
- `LT_TRACK` moves to `LT_HOLD` when the enable goes low.

Top module: `tsense_ctrl`

## Requirements
- R1: A low synchronous reset clears the shift register and the holding word to zero. After reset, `head_b_sel`=0, `src_on`=0, `dac_code`=0, `chan_addr`=0, `chan_onehot`=8'b0000_0001, and `chan_internal`=1.
- R2: Each rising edge of `ser_clk` shifts `ser_data` into the shift register at bit 0. Older bits move toward bit 9, so a word is sent bit 9 first.
- R3: While `latch_en` is high, the decoded outputs follow the shift register after each shift.
- R4: While `latch_en` is low, shifting has no effect on `head_b_sel`, `dac_code`, `chan_addr` or `src_on`.
- R5: `src_on` is 1 only when held bit 8 is 1 and `src_en_n` is 0. Every other combination gives 0.
- R6: `head_b_sel` equals held bit 9. A value of 0 selects head A and 1 selects head B.
- R7: `dac_code` equals held bits 7..3, with bit 7 as the MSB.
- R8: `chan_addr` equals held bits 2..0. `chan_onehot` has exactly one bit set, at index `chan_addr`.
- R9: Exactly one category flag is set:
  - `chan_internal` for address 0;
  - `chan_external` for addresses 1 to 5;
  - `chan_special` for addresses 6 and 7.
- R10: When more than ten bits are shifted before a latch, only the last ten bits are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_data | input | 1 | Serial data, sampled on the rising edge of `ser_clk` |
| latch_en | input | 1 | High: latch transparent; low: hold |
| src_en_n | input | 1 | Active-low external current-source enable |
| head_b_sel | output | 1 | Sense-resistor head select (1 = head B) |
| src_on | output | 1 | Current source enable |
| dac_code | output | 5 | Offset DAC code |
| chan_addr | output | 3 | Converter channel address |
| chan_onehot | output | 8 | One-hot channel select |
| chan_internal | output | 1 | Address selects the internal sense channel |
| chan_external | output | 1 | Address selects an external input |
| chan_special | output | 1 | Address selects a special switch setting |

## Verification
A corrupted shift register shows at the ports as wrong fields after the next latch pulse. With the latch held open, it shows within a few core cycles of the shift. The shifted-in bit lands at a known position, so a stuck or reversed bit shows as a wrong DAC or address value.

A latch controller stuck in `LT_TRACK` lets outputs change while the enable is low, which the hold checks expose. One stuck in `LT_HOLD` never delivers a new word, which the first load exposes. A decode fault shows immediately as a one-hot vector or category flag that disagrees with `chan_addr`.

// File: rtl/tsense_pkg.sv
package tsense_pkg;

    typedef enum logic [0:0] {
        LT_HOLD  = 1'b0,
        LT_TRACK = 1'b1
    } latch_state_e;

endpackage

// File: rtl/tsense_sync.sv
module tsense_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[0] <= '0;
                    else        stg[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[s] <= '0;
                    else        stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/tsense_shift.sv
module tsense_shift #(
    parameter int REG_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_s,
    input  logic             sdat_s,
    output logic [REG_W-1:0] word
);
    logic sclk_prev;
    logic sclk_rise;

    assign sclk_rise = sclk_s & ~sclk_prev;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_prev <= 1'b0;
            word      <= '0;
        end else begin
            sclk_prev <= sclk_s;
            if (sclk_rise) word <= {word[REG_W-2:0], sdat_s};
        end
    end
endmodule

// File: rtl/tsense_latch.sv
module tsense_latch
    import tsense_pkg::*;
#(
    parameter int REG_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             le_s,
    input  logic [REG_W-1:0] sh_word,
    output logic [REG_W-1:0] held,
    output logic             open_o
);
    latch_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LT_HOLD;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LT_HOLD:  if (le_s)  state_d = LT_TRACK;
            LT_TRACK: if (!le_s) state_d = LT_HOLD;
            default:             state_d = LT_HOLD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                  held <= '0;
        else if (state_q == LT_TRACK) held <= sh_word;
    end

    assign open_o = (state_q == LT_TRACK);
endmodule

// File: rtl/tsense_decode.sv
module tsense_decode #(
    parameter int DAC_W  = 5,
    parameter int ADDR_W = 3,
    parameter int N_EXT  = 5
) (
    input  logic [DAC_W+ADDR_W+1:0]  word,
    output logic                     head_b,
    output logic                     on_bit,
    output logic [DAC_W-1:0]         dac,
    output logic [ADDR_W-1:0]        addr,
    output logic [(1<<ADDR_W)-1:0]   onehot,
    output logic                     is_int,
    output logic                     is_ext,
    output logic                     is_spc
);
    localparam int REG_W = DAC_W + ADDR_W + 2;
    localparam int NCH   = 1 << ADDR_W;

    assign head_b = word[REG_W-1];
    assign on_bit = word[REG_W-2];
    assign dac    = word[ADDR_W +: DAC_W];
    assign addr   = word[ADDR_W-1:0];

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_sel
            assign onehot[g] = (addr == ADDR_W'(g));
        end
    endgenerate

    always_comb begin
        is_int = (addr == '0);
        is_ext = !is_int && (int'(addr) <= N_EXT);
        is_spc = !is_int && !is_ext;
    end
endmodule

// File: rtl/tsense_ctrl.sv
module tsense_ctrl #(
    parameter int DAC_W       = 5,
    parameter int ADDR_W      = 3,
    parameter int N_EXT       = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ser_clk,
    input  logic                    ser_data,
    input  logic                    latch_en,
    input  logic                    src_en_n,
    output logic                    head_b_sel,
    output logic                    src_on,
    output logic [DAC_W-1:0]        dac_code,
    output logic [ADDR_W-1:0]       chan_addr,
    output logic [(1<<ADDR_W)-1:0]  chan_onehot,
    output logic                    chan_internal,
    output logic                    chan_external,
    output logic                    chan_special
);
    localparam int REG_W = DAC_W + ADDR_W + 2;

    logic [2:0]       sync_q;
    logic [REG_W-1:0] sh_word;
    logic [REG_W-1:0] held_word;
    logic             latch_open;
    logic             on_bit;

    tsense_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({latch_en, ser_data, ser_clk}),
        .q     (sync_q)
    );

    tsense_shift #(.REG_W(REG_W)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk_s (sync_q[0]),
        .sdat_s (sync_q[1]),
        .word   (sh_word)
    );

    tsense_latch #(.REG_W(REG_W)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .le_s    (sync_q[2]),
        .sh_word (sh_word),
        .held    (held_word),
        .open_o  (latch_open)
    );

    tsense_decode #(.DAC_W(DAC_W), .ADDR_W(ADDR_W), .N_EXT(N_EXT)) u_dec (
        .word   (held_word),
        .head_b (head_b_sel),
        .on_bit (on_bit),
        .dac    (dac_code),
        .addr   (chan_addr),
        .onehot (chan_onehot),
        .is_int (chan_internal),
        .is_ext (chan_external),
        .is_spc (chan_special)
    );

    assign src_on = on_bit & ~src_en_n;
endmodule

// File: rtl/tsense_ctrl_chk.sv
module tsense_ctrl_chk #(
    parameter int DAC_W  = 5,
    parameter int ADDR_W = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   src_en_n,
    input logic                   latch_open,
    input logic                   head_b_sel,
    input logic                   src_on,
    input logic [DAC_W-1:0]       dac_code,
    input logic [ADDR_W-1:0]      chan_addr,
    input logic [(1<<ADDR_W)-1:0] chan_onehot,
    input logic                   chan_internal,
    input logic                   chan_external,
    input logic                   chan_special
);
    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (dac_code == '0 && chan_addr == '0 && !head_b_sel && !src_on));

    // R5
    src_off_pin_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        src_en_n |-> !src_on);

    // R4
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!latch_open && $past(!latch_open)) |->
            ($stable(dac_code) && $stable(chan_addr) && $stable(head_b_sel)));

    // R8
    onehot_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chan_onehot) && chan_onehot[chan_addr]);

    // R9
    one_category_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({chan_internal, chan_external, chan_special}) == 1);

    // R9
    internal_addr0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chan_internal |-> (chan_addr == '0));
endmodule

bind tsense_ctrl tsense_ctrl_chk #(.DAC_W(DAC_W), .ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .src_en_n      (src_en_n),
    .latch_open    (latch_open),
    .head_b_sel    (head_b_sel),
    .src_on        (src_on),
    .dac_code      (dac_code),
    .chan_addr     (chan_addr),
    .chan_onehot   (chan_onehot),
    .chan_internal (chan_internal),
    .chan_external (chan_external),
    .chan_special  (chan_special)
);

// File: tb/tb_tsense_ctrl.sv
module tb_tsense_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_clk = 1'b0;
    logic       ser_data = 1'b0;
    logic       latch_en = 1'b0;
    logic       src_en_n = 1'b1;
    logic       head_b_sel, src_on, chan_internal, chan_external, chan_special;
    logic [4:0] dac_code;
    logic [2:0] chan_addr;
    logic [7:0] chan_onehot;

    always #5 clk = ~clk;

    tsense_ctrl dut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .latch_en(latch_en), .src_en_n(src_en_n), .head_b_sel(head_b_sel),
        .src_on(src_on), .dac_code(dac_code), .chan_addr(chan_addr),
        .chan_onehot(chan_onehot), .chan_internal(chan_internal),
        .chan_external(chan_external), .chan_special(chan_special)
    );

    typedef struct {
        string      tag;
        logic       head;
        logic       on;
        logic [4:0] dac;
        logic [2:0] addr;
        logic [7:0] oh;
        logic [2:0] cat;
    } exp_t;

    exp_t   sb_q[$];
    event   chk_ev;
    int     n_cmp = 0;
    int     n_bad = 0;
    bit     done  = 0;
    logic [9:0] sh_m  = '0;
    logic [9:0] lat_m = '0;

    function automatic exp_t model(string tag, logic [9:0] w, logic en_n);
        exp_t e;
        e.tag  = tag;
        e.head = w[9];
        e.on   = w[8] && !en_n;
        e.dac  = w[7:3];
        e.addr = w[2:0];
        e.oh   = 8'b1 << w[2:0];
        if (w[2:0] == 3'd0)      e.cat = 3'b100;
        else if (w[2:0] <= 3'd5) e.cat = 3'b010;
        else                     e.cat = 3'b001;
        return e;
    endfunction

    task automatic expect_now(string tag);
        sb_q.push_back(model(tag, lat_m, src_en_n));
        -> chk_ev;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_bit(logic b);
        ser_data = b;
        repeat (3) @(negedge clk);
        ser_clk = 1'b1;
        repeat (3) @(negedge clk);
        ser_clk = 1'b0;
        repeat (3) @(negedge clk);
        sh_m = {sh_m[8:0], b};
        if (latch_en) lat_m = sh_m;
    endtask

    task automatic send_word(logic [9:0] w);
        for (int i = 9; i >= 0; i--) send_bit(w[i]);
    endtask

    task automatic pulse_latch();
        latch_en = 1'b1;
        repeat (6) @(negedge clk);
        latch_en = 1'b0;
        repeat (6) @(negedge clk);
        lat_m = sh_m;
    endtask

    // monitor
    initial begin
        forever begin
            @(chk_ev);
            @(negedge clk);
            begin
                exp_t e;
                logic [2:0] cat;
                e = sb_q.pop_front();
                cat = {chan_internal, chan_external, chan_special};
                n_cmp++;
                if (head_b_sel !== e.head || src_on !== e.on || dac_code !== e.dac ||
                    chan_addr !== e.addr || chan_onehot !== e.oh || cat !== e.cat) begin
                    n_bad++;
                    $display("FAIL %s: got head=%0b on=%0b dac=%0d addr=%0d oh=%b cat=%b ; expected head=%0b on=%0b dac=%0d addr=%0d oh=%b cat=%b",
                             e.tag, head_b_sel, src_on, dac_code, chan_addr, chan_onehot, cat,
                             e.head, e.on, e.dac, e.addr, e.oh, e.cat);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // driver
    initial begin
        src_en_n = 1'b0;
        repeat (5) @(negedge clk);
        expect_now("R1 reset state");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        expect_now("R1 after release");

        // R2 R6 R7 R8 R9 R5: head B, on, dac 22, addr 3
        send_word(10'b1_1_10110_011);
        pulse_latch();
        expect_now("R2 R6 R7 R8 load word");
        src_en_n = 1'b1;
        repeat (2) @(negedge clk);
        expect_now("R5 pin high forces off");
        src_en_n = 1'b0;

        send_word(10'b0_0_00001_110);
        pulse_latch();
        expect_now("R5 on bit clear");
        expect_now("R9 special address 6");

        // R4: shift without latching
        send_word(10'b1_1_11111_101);
        expect_now("R4 hold ignores shifting");
        pulse_latch();
        expect_now("R4 word delivered on latch");

        // R3: transparent tracking
        latch_en = 1'b1;
        repeat (6) @(negedge clk);
        lat_m = sh_m;
        expect_now("R3 open latch shows register");
        send_bit(1'b0);
        expect_now("R3 follows shift 1");
        send_bit(1'b1);
        expect_now("R3 follows shift 2");
        send_bit(1'b1);
        expect_now("R3 follows shift 3");
        latch_en = 1'b0;
        repeat (6) @(negedge clk);

        // R10: thirteen bits, last ten kept
        for (int i = 0; i < 3; i++) send_bit(1'b1);
        send_word(10'b0_1_01010_100);
        pulse_latch();
        expect_now("R10 only last ten bits");

        // R8 R9 every address
        for (int a = 0; a < 8; a++) begin
            send_word({2'b01, 5'(a * 3), 3'(a)});
            pulse_latch();
            expect_now($sformatf("R8 R9 address %0d", a));
        end

        // R1 mid-run reset
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        sh_m = '0;
        lat_m = '0;
        repeat (2) @(negedge clk);
        expect_now("R1 reset mid run");

        repeat (4) @(negedge clk);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule